// File: doc/BRIEF.md
# Security-Banked UART Register File

This block is the register front end of a serial port that serves a secure and a non-secure software world at the same time. It is an AXI4-Lite slave with two register banks. Configuration that can disturb the link or raise unexpected interrupts lives only in the secure bank: control, data format, interrupt mask, both baud dividers, receive timeout, modem control and flow-control delay. The FIFO data ports, the FIFO trigger levels, the interrupt status and the channel status each exist as a secure copy and a separate non-secure copy. One modem status word is shared by both worlds.

Every transaction carries its world in protection bit 1 of the address channel: 0 is secure, 1 is non-secure. Write permission comes from the write address channel and read permission from the read address channel, each judged on its own. A secure requester reaches every register. A non-secure requester reaches only the non-secure copies and the shared modem status. The block drives the stored configuration, FIFO push and pop strobes and two interrupt lines to the serial core. It takes status words, receive FIFO head data and interrupt events from that core.

Top module: `uart_sec_regfile`

## Requirements
- R1: After reset every configuration output, the interrupt mask and both interrupt status words are zero, no response is pending, and awready, wready and arready are high.
- R2: A secure access can write and read back every stored secure register. Word index is address bits [7:2], bits [1:0] are ignored. The indices are: control 0, mode 1, baud generator 6, receive timeout 7, secure RX trigger 8, modem control 9, baud divider 13, flow delay 14, secure TX trigger 15.
- R3: A write with awprot[1]=1 to a secure-only register changes no state and answers SLVERR (2'b10). Secure-only means indices 0 to 16 except 10.
- R4: A read with arprot[1]=1 of a secure-only register returns zero data with SLVERR and does not pop the secure receive FIFO.
- R5: The non-secure copies are reachable from both worlds: NS RX trigger 17, NS TX trigger 18, NS RX FIFO 19, NS TX FIFO 20, NS interrupt status 21, NS channel status 22. Secure RX FIFO is 16, secure channel status is 11.
- R6: Modem status (index 10) reads the modem_stat input from either world with OKAY, and a write from either world answers OKAY and changes nothing.
- R7: A hardware event sets bits in its world's interrupt status. The status words at 5 (secure) and 21 (non-secure) clear where a 1 is written. A non-secure requester can clear only the non-secure word.
- R8: A 1 written to interrupt enable (2) sets a mask bit, and a 1 written to interrupt disable (3) clears it. Mask index 4 reads the mask, while 2 and 3 read zero. fiq is the OR of secure status AND mask, and irq is the OR of non-secure status AND mask.
- R9: An accepted write to 12 or 20 gives one-cycle pulses on sec_tx_push or ns_tx_push, carrying the write data on tx_push_data. A refused write pushes nothing.
- R10: An accepted read of 16 or 19 pulses sec_rx_pop or ns_rx_pop in the handshake cycle and returns that FIFO's head data.
- R11: Any index above 22 answers DECERR (2'b11), with read data zero and no state change.
- R12: Write address and write data are accepted in any order. bvalid and rvalid, together with their response and data, hold until bready or rready.
- R13: wstrb byte lanes gate updates to stored registers, to the interrupt enable and disable, and to the status clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| awprot | input | 3 | Write protection, bit 1 = non-secure |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| arprot | input | 3 | Read protection, bit 1 = non-secure |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| cfg_ctrl | output | DATA_W | Control word |
| cfg_mode | output | DATA_W | Data format word |
| cfg_baud_gen | output | DATA_W | Reference clock divider |
| cfg_baud_div | output | DATA_W | Sample divider |
| cfg_rx_timeout | output | DATA_W | Receive idle timeout |
| cfg_modem_ctl | output | DATA_W | Modem control word |
| cfg_flow_delay | output | DATA_W | Flow control level |
| cfg_irq_mask | output | DATA_W | Interrupt mask |
| cfg_sec_rx_trig | output | DATA_W | Secure RX trigger level |
| cfg_sec_tx_trig | output | DATA_W | Secure TX trigger level |
| cfg_ns_rx_trig | output | DATA_W | Non-secure RX trigger level |
| cfg_ns_tx_trig | output | DATA_W | Non-secure TX trigger level |
| sec_tx_push | output | 1 | Push secure TX FIFO |
| ns_tx_push | output | 1 | Push non-secure TX FIFO |
| tx_push_data | output | DATA_W | Data for a TX push |
| sec_rx_pop | output | 1 | Pop secure RX FIFO |
| ns_rx_pop | output | 1 | Pop non-secure RX FIFO |
| sec_rx_data | input | DATA_W | Secure RX FIFO head |
| ns_rx_data | input | DATA_W | Non-secure RX FIFO head |
| sec_chan_stat | input | DATA_W | Secure channel status |
| ns_chan_stat | input | DATA_W | Non-secure channel status |
| modem_stat | input | DATA_W | Shared modem status |
| sec_irq_evt | input | DATA_W | Secure interrupt event bits |
| ns_irq_evt | input | DATA_W | Non-secure interrupt event bits |
| fiq | output | 1 | Secure interrupt |
| irq | output | 1 | Non-secure interrupt |

## Verification
The assertions assume that a master follows AXI4-Lite. It keeps a raised valid until ready and keeps address, protection and data stable meanwhile. The assertions also take arprot as meaningful only while arvalid is high. The stimulus raises each valid for exactly the cycle the block is known to be ready: it drops valid after the accepting edge and never issues a new request while a response is outstanding. Interrupt events are one-cycle pulses driven away from the clock edge, so the response holds and the pop and push exclusivity checks see only legal traffic.

// File: rtl/uart_sec_pkg.sv
package uart_sec_pkg;

    // Word index of each register; the index is the access policy key.
    typedef enum logic [4:0] {
        REG_CTRL      = 5'd0,
        REG_MODE      = 5'd1,
        REG_IEN       = 5'd2,
        REG_IDIS      = 5'd3,
        REG_IMASK     = 5'd4,
        REG_S_ISR     = 5'd5,
        REG_BGEN      = 5'd6,
        REG_RXTO      = 5'd7,
        REG_S_RXTRIG  = 5'd8,
        REG_MCTL      = 5'd9,
        REG_MSTAT     = 5'd10,
        REG_S_CHST    = 5'd11,
        REG_S_TXF     = 5'd12,
        REG_BDIV      = 5'd13,
        REG_FDLY      = 5'd14,
        REG_S_TXTRIG  = 5'd15,
        REG_S_RXF     = 5'd16,
        REG_NS_RXTRIG = 5'd17,
        REG_NS_TXTRIG = 5'd18,
        REG_NS_RXF    = 5'd19,
        REG_NS_TXF    = 5'd20,
        REG_NS_ISR    = 5'd21,
        REG_NS_CHST   = 5'd22
    } reg_id_e;

    localparam int NUM_REGS = 23;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/uart_sec_decode.sv
module uart_sec_decode
    import uart_sec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_id_e           id_o,
    output logic              hit_o,
    output logic              sec_only_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic [1:0]       unused_lsb;

    assign widx       = addr_i[ADDR_W-1:2];
    assign unused_lsb = addr_i[1:0];

    always_comb begin
        hit_o      = (widx < IDX_W'(NUM_REGS));
        id_o       = hit_o ? reg_id_e'(widx[4:0]) : REG_CTRL;
        sec_only_o = hit_o && (id_o <= REG_S_RXF) && (id_o != REG_MSTAT);
    end
endmodule

// File: rtl/uart_sec_isr.sv
module uart_sec_isr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] clr_i,
    output logic [DATA_W-1:0] isr_o
);
    logic [DATA_W-1:0] isr_d, isr_q;

    always_comb begin
        isr_d = (isr_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    assign isr_o = isr_q;
endmodule

// File: rtl/uart_sec_regfile.sv
module uart_sec_regfile
    import uart_sec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awvalid,
    output logic                awready,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic [2:0]          awprot,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic                bvalid,
    input  logic                bready,
    output logic [1:0]          bresp,
    input  logic                arvalid,
    output logic                arready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic [2:0]          arprot,
    output logic                rvalid,
    input  logic                rready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic [DATA_W-1:0]   cfg_ctrl,
    output logic [DATA_W-1:0]   cfg_mode,
    output logic [DATA_W-1:0]   cfg_baud_gen,
    output logic [DATA_W-1:0]   cfg_baud_div,
    output logic [DATA_W-1:0]   cfg_rx_timeout,
    output logic [DATA_W-1:0]   cfg_modem_ctl,
    output logic [DATA_W-1:0]   cfg_flow_delay,
    output logic [DATA_W-1:0]   cfg_irq_mask,
    output logic [DATA_W-1:0]   cfg_sec_rx_trig,
    output logic [DATA_W-1:0]   cfg_sec_tx_trig,
    output logic [DATA_W-1:0]   cfg_ns_rx_trig,
    output logic [DATA_W-1:0]   cfg_ns_tx_trig,
    output logic                sec_tx_push,
    output logic                ns_tx_push,
    output logic [DATA_W-1:0]   tx_push_data,
    output logic                sec_rx_pop,
    output logic                ns_rx_pop,
    input  logic [DATA_W-1:0]   sec_rx_data,
    input  logic [DATA_W-1:0]   ns_rx_data,
    input  logic [DATA_W-1:0]   sec_chan_stat,
    input  logic [DATA_W-1:0]   ns_chan_stat,
    input  logic [DATA_W-1:0]   modem_stat,
    input  logic [DATA_W-1:0]   sec_irq_evt,
    input  logic [DATA_W-1:0]   ns_irq_evt,
    output logic                fiq,
    output logic                irq
);
    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        logic              aw_vld;
        logic [ADDR_W-1:0] aw_addr;
        logic              aw_ns;
        logic              w_vld;
        logic [DATA_W-1:0] w_data;
        logic [STRB_W-1:0] w_strb;
        logic              b_vld;
        logic [1:0]        b_resp;
        logic              r_vld;
        logic [DATA_W-1:0] r_data;
        logic [1:0]        r_resp;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] imask;
        logic [DATA_W-1:0] bgen;
        logic [DATA_W-1:0] rxto;
        logic [DATA_W-1:0] s_rxtrig;
        logic [DATA_W-1:0] mctl;
        logic [DATA_W-1:0] bdiv;
        logic [DATA_W-1:0] fdly;
        logic [DATA_W-1:0] s_txtrig;
        logic [DATA_W-1:0] ns_rxtrig;
        logic [DATA_W-1:0] ns_txtrig;
    } state_t;

    state_t st_d, st_q;

    reg_id_e           wr_id, rd_id;
    logic              wr_hit, wr_sec_only, rd_hit, rd_sec_only;
    logic [DATA_W-1:0] s_isr, ns_isr, s_isr_clr, ns_isr_clr;
    logic [DATA_W-1:0] bm, wv, rd_val;
    logic              wr_exec, ar_hs;
    logic              unused_prot;

    assign unused_prot = ^{awprot[2], awprot[0], arprot[2], arprot[0]};

    function automatic logic [DATA_W-1:0] lane_mask(input logic [STRB_W-1:0] s);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < STRB_W; i++) m[i*8 +: 8] = {8{s[i]}};
        return m;
    endfunction

    uart_sec_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
        .addr_i(st_q.aw_addr), .id_o(wr_id), .hit_o(wr_hit), .sec_only_o(wr_sec_only)
    );

    uart_sec_decode #(.ADDR_W(ADDR_W)) u_rd_dec (
        .addr_i(araddr), .id_o(rd_id), .hit_o(rd_hit), .sec_only_o(rd_sec_only)
    );

    uart_sec_isr #(.DATA_W(DATA_W)) u_s_isr (
        .clk(clk), .rst_n(rst_n), .set_i(sec_irq_evt), .clr_i(s_isr_clr), .isr_o(s_isr)
    );

    uart_sec_isr #(.DATA_W(DATA_W)) u_ns_isr (
        .clk(clk), .rst_n(rst_n), .set_i(ns_irq_evt), .clr_i(ns_isr_clr), .isr_o(ns_isr)
    );

    // Read source for a permitted read
    always_comb begin
        case (rd_id)
            REG_CTRL:      rd_val = st_q.ctrl;
            REG_MODE:      rd_val = st_q.mode;
            REG_IMASK:     rd_val = st_q.imask;
            REG_S_ISR:     rd_val = s_isr;
            REG_BGEN:      rd_val = st_q.bgen;
            REG_RXTO:      rd_val = st_q.rxto;
            REG_S_RXTRIG:  rd_val = st_q.s_rxtrig;
            REG_MCTL:      rd_val = st_q.mctl;
            REG_MSTAT:     rd_val = modem_stat;
            REG_S_CHST:    rd_val = sec_chan_stat;
            REG_BDIV:      rd_val = st_q.bdiv;
            REG_FDLY:      rd_val = st_q.fdly;
            REG_S_TXTRIG:  rd_val = st_q.s_txtrig;
            REG_S_RXF:     rd_val = sec_rx_data;
            REG_NS_RXTRIG: rd_val = st_q.ns_rxtrig;
            REG_NS_TXTRIG: rd_val = st_q.ns_txtrig;
            REG_NS_RXF:    rd_val = ns_rx_data;
            REG_NS_ISR:    rd_val = ns_isr;
            REG_NS_CHST:   rd_val = ns_chan_stat;
            default:       rd_val = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        s_isr_clr   = '0;
        ns_isr_clr  = '0;
        sec_tx_push = 1'b0;
        ns_tx_push  = 1'b0;
        sec_rx_pop  = 1'b0;
        ns_rx_pop   = 1'b0;
        bm          = lane_mask(st_q.w_strb);
        wv          = st_q.w_data & bm;
        wr_exec     = st_q.aw_vld && st_q.w_vld && !st_q.b_vld;
        ar_hs       = arvalid && !st_q.r_vld;

        // Independent capture of address and data
        if (awvalid && !st_q.aw_vld) begin
            st_d.aw_vld  = 1'b1;
            st_d.aw_addr = awaddr;
            st_d.aw_ns   = awprot[1];
        end
        if (wvalid && !st_q.w_vld) begin
            st_d.w_vld  = 1'b1;
            st_d.w_data = wdata;
            st_d.w_strb = wstrb;
        end
        if (st_q.b_vld && bready) st_d.b_vld = 1'b0;

        if (wr_exec) begin
            st_d.aw_vld = 1'b0;
            st_d.w_vld  = 1'b0;
            st_d.b_vld  = 1'b1;
            if (!wr_hit) begin
                st_d.b_resp = RESP_DECERR;
            end else if (wr_sec_only && st_q.aw_ns) begin
                st_d.b_resp = RESP_SLVERR;
            end else begin
                st_d.b_resp = RESP_OKAY;
                case (wr_id)
                    REG_CTRL:      st_d.ctrl      = (st_q.ctrl & ~bm) | wv;
                    REG_MODE:      st_d.mode      = (st_q.mode & ~bm) | wv;
                    REG_IEN:       st_d.imask     = st_q.imask | wv;
                    REG_IDIS:      st_d.imask     = st_q.imask & ~wv;
                    REG_S_ISR:     s_isr_clr      = wv;
                    REG_BGEN:      st_d.bgen      = (st_q.bgen & ~bm) | wv;
                    REG_RXTO:      st_d.rxto      = (st_q.rxto & ~bm) | wv;
                    REG_S_RXTRIG:  st_d.s_rxtrig  = (st_q.s_rxtrig & ~bm) | wv;
                    REG_MCTL:      st_d.mctl      = (st_q.mctl & ~bm) | wv;
                    REG_S_TXF:     sec_tx_push    = 1'b1;
                    REG_BDIV:      st_d.bdiv      = (st_q.bdiv & ~bm) | wv;
                    REG_FDLY:      st_d.fdly      = (st_q.fdly & ~bm) | wv;
                    REG_S_TXTRIG:  st_d.s_txtrig  = (st_q.s_txtrig & ~bm) | wv;
                    REG_NS_RXTRIG: st_d.ns_rxtrig = (st_q.ns_rxtrig & ~bm) | wv;
                    REG_NS_TXTRIG: st_d.ns_txtrig = (st_q.ns_txtrig & ~bm) | wv;
                    REG_NS_TXF:    ns_tx_push     = 1'b1;
                    REG_NS_ISR:    ns_isr_clr     = wv;
                    default: ;
                endcase
            end
        end

        if (st_q.r_vld && rready) st_d.r_vld = 1'b0;
        if (ar_hs) begin
            st_d.r_vld = 1'b1;
            if (!rd_hit) begin
                st_d.r_resp = RESP_DECERR;
                st_d.r_data = '0;
            end else if (rd_sec_only && arprot[1]) begin
                st_d.r_resp = RESP_SLVERR;
                st_d.r_data = '0;
            end else begin
                st_d.r_resp = RESP_OKAY;
                st_d.r_data = rd_val;
                sec_rx_pop  = (rd_id == REG_S_RXF);
                ns_rx_pop   = (rd_id == REG_NS_RXF);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign awready         = !st_q.aw_vld;
    assign wready          = !st_q.w_vld;
    assign bvalid          = st_q.b_vld;
    assign bresp           = st_q.b_resp;
    assign arready         = !st_q.r_vld;
    assign rvalid          = st_q.r_vld;
    assign rdata           = st_q.r_data;
    assign rresp           = st_q.r_resp;
    assign cfg_ctrl        = st_q.ctrl;
    assign cfg_mode        = st_q.mode;
    assign cfg_baud_gen    = st_q.bgen;
    assign cfg_baud_div    = st_q.bdiv;
    assign cfg_rx_timeout  = st_q.rxto;
    assign cfg_modem_ctl   = st_q.mctl;
    assign cfg_flow_delay  = st_q.fdly;
    assign cfg_irq_mask    = st_q.imask;
    assign cfg_sec_rx_trig = st_q.s_rxtrig;
    assign cfg_sec_tx_trig = st_q.s_txtrig;
    assign cfg_ns_rx_trig  = st_q.ns_rxtrig;
    assign cfg_ns_tx_trig  = st_q.ns_txtrig;
    assign tx_push_data    = st_q.w_data;
    assign fiq             = |(s_isr & st_q.imask);
    assign irq             = |(ns_isr & st_q.imask);
endmodule

// File: rtl/uart_sec_regfile_chk.sv
module uart_sec_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              arvalid,
    input logic              arready,
    input logic [2:0]        arprot,
    input logic              sec_tx_push,
    input logic              ns_tx_push,
    input logic              sec_rx_pop,
    input logic              ns_rx_pop,
    input logic              fiq,
    input logic              irq,
    input logic [DATA_W-1:0] cfg_irq_mask
);
    logic unused_bits;
    assign unused_bits = ^{arprot[2], arprot[0]};

    p_bresp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid && $stable(bresp));

    p_rresp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));

    p_push_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sec_tx_push, ns_tx_push}));

    p_pop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sec_rx_pop, ns_rx_pop}));

    p_ns_no_sec_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready && arprot[1] |-> !sec_rx_pop);

    p_pop_gives_okay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_rx_pop || ns_rx_pop) |=> rvalid && (rresp == 2'b00));

    p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && (rresp != 2'b00) |-> (rdata == '0));

    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq || irq) |-> (cfg_irq_mask != '0));
endmodule

bind uart_sec_regfile uart_sec_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_uart_sec_regfile.sv
`timescale 1ns/1ps
module tb_uart_sec_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic [2:0]  awprot = '0, arprot = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [31:0] cfg_ctrl, cfg_mode, cfg_baud_gen, cfg_baud_div, cfg_rx_timeout;
    logic [31:0] cfg_modem_ctl, cfg_flow_delay, cfg_irq_mask;
    logic [31:0] cfg_sec_rx_trig, cfg_sec_tx_trig, cfg_ns_rx_trig, cfg_ns_tx_trig;
    logic        sec_tx_push, ns_tx_push, sec_rx_pop, ns_rx_pop, fiq, irq;
    logic [31:0] tx_push_data;
    logic [31:0] sec_rx_data = 32'hC0DE_0001, ns_rx_data = 32'hBEEF_0002;
    logic [31:0] sec_chan_stat = 32'h0000_0011, ns_chan_stat = 32'h0000_0022;
    logic [31:0] modem_stat = 32'h0000_00A5;
    logic [31:0] sec_irq_evt = '0, ns_irq_evt = '0;

    always #2.5 clk = ~clk;

    uart_sec_regfile dut (.*);

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] m_reg [0:22];
    logic [31:0] m_imask = '0, m_sisr = '0, m_nsisr = '0;
    bit          pend_wr = 0;
    int          pend_idx = 0;
    bit          pend_ns = 0;
    logic [31:0] pend_d = '0, pend_sevt = '0, pend_nsevt = '0;
    logic [3:0]  pend_strb = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit sec_only(input int idx);
        return idx <= 16 && idx != 10;
    endfunction

    function automatic logic [1:0] resp_of(input int idx, input bit ns);
        if (idx > 22) return 2'b11;
        if (ns && sec_only(idx)) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [31:0] lanes(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    task automatic apply_pending();
        logic [31:0] sclr = '0, nsclr = '0, bm, v;
        if (pend_wr && resp_of(pend_idx, pend_ns) == 2'b00) begin
            bm = lanes(pend_strb);
            v  = pend_d & bm;
            case (pend_idx)
                2:  m_imask = m_imask | v;
                3:  m_imask = m_imask & ~v;
                5:  sclr = v;
                21: nsclr = v;
                0, 1, 6, 7, 8, 9, 13, 14, 15, 17, 18:
                    m_reg[pend_idx] = (m_reg[pend_idx] & ~bm) | v;
                default: ;
            endcase
        end
        m_sisr   = (m_sisr & ~sclr) | pend_sevt;
        m_nsisr  = (m_nsisr & ~nsclr) | pend_nsevt;
        pend_wr  = 0;
        pend_sevt = '0;
        pend_nsevt = '0;
    endtask

    task automatic compare_all();
        check(cfg_ctrl == m_reg[0] && cfg_mode == m_reg[1] && cfg_baud_gen == m_reg[6] &&
              cfg_rx_timeout == m_reg[7] && cfg_sec_rx_trig == m_reg[8] &&
              cfg_modem_ctl == m_reg[9] && cfg_baud_div == m_reg[13] &&
              cfg_flow_delay == m_reg[14] && cfg_sec_tx_trig == m_reg[15],
              "R2/R3 secure cfg outputs", cfg_ctrl, m_reg[0]);
        check(cfg_ns_rx_trig == m_reg[17] && cfg_ns_tx_trig == m_reg[18],
              "R5 ns trigger outputs", cfg_ns_rx_trig, m_reg[17]);
        check(cfg_irq_mask == m_imask, "R8 mask output", cfg_irq_mask, m_imask);
        check(fiq == |(m_sisr & m_imask) && irq == |(m_nsisr & m_imask),
              "R7/R8 fiq irq", {30'd0, fiq, irq}, {30'd0, |(m_sisr & m_imask), |(m_nsisr & m_imask)});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        apply_pending();
        compare_all();
    endtask

    function automatic logic [31:0] model_read(input int idx);
        case (idx)
            4:  return m_imask;
            5:  return m_sisr;
            10: return modem_stat;
            11: return sec_chan_stat;
            16: return sec_rx_data;
            19: return ns_rx_data;
            21: return m_nsisr;
            22: return ns_chan_stat;
            2, 3, 12, 20: return '0;
            default: return (idx <= 22) ? m_reg[idx] : '0;
        endcase
    endfunction

    task automatic wr(input int idx, input bit ns, input logic [31:0] d,
                      input logic [3:0] strb, input string tag);
        logic [1:0] er = resp_of(idx, ns);
        bit sp = (er == 2'b00) && idx == 12;
        bit np = (er == 2'b00) && idx == 20;
        awaddr = 8'(idx * 4); awprot = ns ? 3'b010 : 3'b000;
        wdata = d; wstrb = strb; awvalid = 1; wvalid = 1;
        step();
        awvalid = 0; wvalid = 0;
        check(sec_tx_push == sp && ns_tx_push == np, {tag, " push strobes"},
              {30'd0, sec_tx_push, ns_tx_push}, {30'd0, sp, np});
        if (sp || np) check(tx_push_data == d, {tag, " push data"}, tx_push_data, d);
        pend_wr = 1; pend_idx = idx; pend_ns = ns; pend_d = d; pend_strb = strb;
        step();
        check(bvalid && bresp == er, {tag, " bresp"}, {29'd0, bvalid, bresp}, {29'd0, 1'b1, er});
        step();
        check(!bvalid, {tag, " bvalid drop"}, {31'd0, bvalid}, 32'd0);
    endtask

    task automatic rd(input int idx, input bit ns, input string tag);
        logic [1:0]  er = resp_of(idx, ns);
        logic [31:0] ed = (er == 2'b00) ? model_read(idx) : '0;
        bit sp = (er == 2'b00) && idx == 16;
        bit np = (er == 2'b00) && idx == 19;
        araddr = 8'(idx * 4); arprot = ns ? 3'b010 : 3'b000; arvalid = 1;
        #1;
        check(sec_rx_pop == sp && ns_rx_pop == np, {tag, " pop strobes"},
              {30'd0, sec_rx_pop, ns_rx_pop}, {30'd0, sp, np});
        step();
        arvalid = 0;
        check(rvalid && rresp == er, {tag, " rresp"}, {29'd0, rvalid, rresp}, {29'd0, 1'b1, er});
        check(rdata == ed, {tag, " rdata"}, rdata, ed);
        step();
        check(!rvalid, {tag, " rvalid drop"}, {31'd0, rvalid}, 32'd0);
    endtask

    task automatic evt(input logic [31:0] s, input logic [31:0] n);
        sec_irq_evt = s; ns_irq_evt = n; pend_sevt = s; pend_nsevt = n;
        step();
        sec_irq_evt = '0; ns_irq_evt = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i <= 22; i++) m_reg[i] = '0;
        step(); step();
        // R1 reset state
        check(awready && wready && arready && !bvalid && !rvalid, "R1 handshake reset",
              {27'd0, awready, wready, arready, bvalid, rvalid}, 32'h1C);
        #1 rst_n = 1;
        step();

        // R2 secure stored registers
        wr(0, 0, 32'h1122_3344, 4'hF, "R2 ctrl");
        wr(1, 0, 32'h0000_0C03, 4'hF, "R2 mode");
        wr(6, 0, 32'h0000_0145, 4'hF, "R2 baud gen");
        wr(7, 0, 32'h0000_0020, 4'hF, "R2 timeout");
        wr(9, 0, 32'h0000_0003, 4'hF, "R2 modem ctl");
        wr(13, 0, 32'h0000_0006, 4'hF, "R2 baud div");
        wr(14, 0, 32'h0000_0010, 4'hF, "R2 flow delay");
        wr(8, 0, 32'h0000_0008, 4'hF, "R2 s rx trig");
        wr(15, 0, 32'h0000_0004, 4'hF, "R2 s tx trig");
        rd(0, 0, "R2 ctrl rb");
        rd(6, 0, "R2 baud gen rb");
        rd(14, 0, "R2 flow delay rb");
        rd(11, 0, "R5 s chan stat");

        // R13 byte strobes
        wr(6, 0, 32'hAAAA_AAAA, 4'b0010, "R13 one lane");
        rd(6, 0, "R13 lane rb");
        wr(1, 0, 32'h5555_5555, 4'b0000, "R13 no lane");

        // R3 non-secure writes to secure-only registers
        wr(0, 1, 32'hDEAD_BEEF, 4'hF, "R3 ns ctrl");
        wr(13, 1, 32'hFFFF_FFFF, 4'hF, "R3 ns baud div");
        wr(9, 1, 32'h0, 4'hF, "R3 ns modem ctl");
        rd(0, 0, "R3 ctrl kept");

        // R4 non-secure reads of secure-only registers
        rd(0, 1, "R4 ns ctrl read");
        rd(16, 1, "R4 ns s rxfifo read");
        rd(11, 1, "R4 ns s chan stat");

        // R5 non-secure bank from both worlds
        wr(17, 1, 32'h0000_0030, 4'hF, "R5 ns rx trig ns");
        wr(18, 0, 32'h0000_0002, 4'hF, "R5 ns tx trig s");
        rd(17, 0, "R5 ns rx trig s rb");
        rd(18, 1, "R5 ns tx trig ns rb");
        rd(22, 1, "R5 ns chan stat");

        // R6 shared modem status
        rd(10, 1, "R6 ns modem stat");
        rd(10, 0, "R6 s modem stat");
        wr(10, 1, 32'hFFFF_FFFF, 4'hF, "R6 ns write");
        wr(10, 0, 32'hFFFF_FFFF, 4'hF, "R6 s write");
        rd(10, 1, "R6 unchanged");

        // R8 mask
        wr(2, 0, 32'h0000_0007, 4'hF, "R8 enable");
        wr(3, 0, 32'h0000_0001, 4'hF, "R8 disable");
        wr(2, 1, 32'h0000_0001, 4'hF, "R8 ns enable refused");
        rd(4, 0, "R8 mask rb");
        rd(2, 0, "R8 enable reads zero");

        // R7 interrupt status
        evt(32'h0000_0004, 32'h0000_0006);
        step();
        rd(5, 0, "R7 s status");
        rd(21, 1, "R7 ns status");
        wr(21, 1, 32'h0000_0002, 4'hF, "R7 ns clear");
        rd(21, 1, "R7 ns after clear");
        wr(5, 1, 32'hFFFF_FFFF, 4'hF, "R7 ns clear of s refused");
        rd(5, 0, "R7 s kept");
        wr(5, 0, 32'h0000_0004, 4'hF, "R7 s clear");
        wr(21, 0, 32'h0000_0004, 4'b0000, "R13 status clear no lane");
        rd(21, 0, "R13 ns status kept");

        // R9 TX pushes
        wr(12, 0, 32'h0000_0041, 4'hF, "R9 s push");
        wr(20, 1, 32'h0000_0042, 4'hF, "R9 ns push");
        wr(12, 1, 32'h0000_0043, 4'hF, "R9 ns to s fifo refused");

        // R10 RX pops
        rd(16, 0, "R10 s pop");
        rd(19, 1, "R10 ns pop");
        rd(19, 0, "R10 s reads ns fifo");

        // R11 unmapped
        wr(23, 0, 32'h1234_5678, 4'hF, "R11 write");
        rd(31, 0, "R11 read");
        rd(23, 1, "R11 ns read");

        // R12 data before address, held response
        bready = 0;
        wdata = 32'h0000_00F0; wstrb = 4'hF; wvalid = 1;
        step();
        wvalid = 0;
        check(!wready && awready && !bvalid, "R12 data held alone",
              {29'd0, wready, awready, bvalid}, 32'h2);
        awaddr = 8'd36; awprot = 3'b000; awvalid = 1;
        step();
        awvalid = 0;
        pend_wr = 1; pend_idx = 9; pend_ns = 0; pend_d = 32'h0000_00F0; pend_strb = 4'hF;
        step();
        check(bvalid && bresp == 2'b00, "R12 resp after both", {29'd0, bvalid, bresp}, 32'h4);
        step(); step();
        check(bvalid && bresp == 2'b00, "R12 bvalid held", {29'd0, bvalid, bresp}, 32'h4);
        bready = 1;
        step();
        check(!bvalid, "R12 bvalid released", {31'd0, bvalid}, 32'd0);

        rready = 0;
        araddr = 8'd36; arprot = 3'b000; arvalid = 1;
        step();
        arvalid = 0;
        step(); step();
        check(rvalid && rdata == 32'h0000_00F0 && !arready, "R12 rvalid held", rdata, 32'h0000_00F0);
        rready = 1;
        step();
        check(!rvalid && arready, "R12 rvalid released", {30'd0, rvalid, arready}, 32'h1);

        step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule